// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Event Counter

The block holds two timer/counters behind a small byte-wide register port. Each counter has four settings: a run bit, a gate qualifier, a choice between counting internal time and counting events, and a two-bit mode. In timer function a counter advances once per machine cycle. A machine cycle is a fixed number of input clocks, twelve by default. In counter function it advances once for each falling edge seen on its event pin. That pin passes through a synchronizer and is sampled once per machine cycle. When a counter rolls over, it raises an overflow flag that software clears with a write-one-to-clear access.

The counters support four modes. Mode 0 puts a 5-bit prescaler in front of an 8-bit count, 13 bits in all. Mode 1 is a plain 16-bit count. Mode 2 is an 8-bit count that reloads from the high byte each time it overflows. Mode 3 exists on the first counter only and splits it into two independent 8-bit counts. The upper of these counts machine cycles under the second counter's run bit and takes over the second counter's flag. The second counter keeps running in its own mode, but only its one-cycle overflow pulse output still reports its rollovers. A gate pin can qualify counting, so the block can measure the width of a pulse.

Top module: `tmr_pair`

## Requirements
- R1: While reset is low, and on the first cycle after it, every register reads 0 and `t1_ovf` is low.
- R2: A machine-cycle tick occurs every 12 clocks, the first one 12 clocks after reset. In timer function (select bit 0), a running counter advances by one on each tick.
- R3: In counter function (select bit 1), a counter advances on a tick when the synchronized event pin reads 0 at that tick and read 1 at the previous tick. The pin passes through two register stages before it is sampled.
- R4: A counter advances only when its run bit is 1 and either its gate-mode bit is 0 or its synchronized gate pin is 1. Otherwise its count holds.
- R5: In mode 0 (code 0), bits 4:0 of the low byte are a prescaler. It carries into the high byte when it wraps from 31. Low-byte bits 7:5 hold. Overflow occurs when the high byte wraps from 0xFF.
- R6: In mode 1 (code 1), high and low bytes form one 16-bit count that overflows from 0xFFFF to 0.
- R7: In mode 2 (code 2), the low byte counts. On a step from 0xFF, the low byte loads the high byte and an overflow occurs.
- R8: With counter 0 in mode 3 (code 3), its low byte is an 8-bit count under counter 0's run, gate and select bits, and it sets flag bit 0. Its high byte is an 8-bit count of ticks under run bit 1 that sets flag bit 1 when it wraps from 0xFF.
- R9: While counter 0 is in mode 3, a rollover of counter 1 leaves flag bit 1 unchanged. Every rollover of counter 1 drives `t1_ovf` high for exactly the next cycle.
- R10: An overflow sets its flag. Writing a 1 to a bit of the flag register (address 2) clears that flag. If a clear and a set fall in the same cycle, the flag ends up set.
- R11: A write to a count byte loads that byte and cancels that cycle's increment of the counter owning it (both bytes in modes 0 to 2, only the written half in the mode 3 split), including any overflow.
- R12: Counter 1 in mode 3 holds its count and never overflows, but still accepts writes.
- R13: Register map: address 0 is the mode byte, laid out as [1:0] mode, [2] select and [3] gate-mode for counter 0, and [5:4], [6], [7] for counter 1. Address 1 holds run bits [1:0]. Address 2 holds the flags [1:0]. Addresses 3 and 4 are counter 0 low and high, and 5 and 6 are counter 1 low and high. Every other read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, combinational from the registers |
| ev0_pin | input | 1 | Event input of counter 0 |
| ev1_pin | input | 1 | Event input of counter 1 |
| gate0_pin | input | 1 | Gate input of counter 0 |
| gate1_pin | input | 1 | Gate input of counter 1 |
| t1_ovf | output | 1 | One-cycle pulse after each rollover of counter 1 |

## Verification
Two pairs of functions can meet in one cycle. The first is an overflow that sets a flag and a software write that clears the same flag. The bench provokes it by running counter 0 in mode 2 with a reload of 0xFF, so the counter overflows on every tick, while the clear strobe is held active for a long stretch. The flag must then read 1 right after each tick and 0 one cycle later. The second pair is a count-byte write landing on the cycle of a tick. The bench sweeps writes across every phase of the machine cycle, and a behavioural model checks that each written value survives unchanged and that no increment or flag leaks through.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_FULL16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT   = 2'd3
  } tmode_e;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_RUN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] A_T0L  = 3'd3;
  localparam logic [ADDR_W-1:0] A_T0H  = 3'd4;
  localparam logic [ADDR_W-1:0] A_T1L  = 3'd5;
  localparam logic [ADDR_W-1:0] A_T1H  = 3'd6;

  typedef struct packed {
    logic              ovf;
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
  } step_t;

  // one byte incremented, carry out in the top bit
  function automatic logic [BYTE_W:0] byte_inc(input logic [BYTE_W-1:0] v);
    return {1'b0, v} + {{BYTE_W{1'b0}}, 1'b1};
  endfunction

  // one count step of a whole counter in modes 0 to 2
  function automatic step_t cnt_step(input tmode_e m,
                                     input logic [BYTE_W-1:0] lo,
                                     input logic [BYTE_W-1:0] hi);
    step_t r;
    logic [PRE_W:0] pre;
    logic [BYTE_W:0] hb;
    logic [2*BYTE_W:0] wide;
    r.ovf = 1'b0;
    r.lo  = lo;
    r.hi  = hi;
    case (m)
      MD_PRE13: begin
        pre = {1'b0, lo[PRE_W-1:0]} + {{PRE_W{1'b0}}, 1'b1};
        r.lo[PRE_W-1:0] = pre[PRE_W-1:0];
        if (pre[PRE_W]) begin
          hb    = byte_inc(hi);
          r.hi  = hb[BYTE_W-1:0];
          r.ovf = hb[BYTE_W];
        end
      end
      MD_FULL16: begin
        wide  = {1'b0, hi, lo} + {{(2*BYTE_W){1'b0}}, 1'b1};
        r.ovf = wide[2*BYTE_W];
        r.hi  = wide[2*BYTE_W-1:BYTE_W];
        r.lo  = wide[BYTE_W-1:0];
      end
      MD_RELOAD8: begin
        if (&lo) begin
          r.lo  = hi;
          r.ovf = 1'b1;
        end else begin
          hb   = byte_inc(lo);
          r.lo = hb[BYTE_W-1:0];
        end
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_pair_sampler.sv
module tmr_pair_sampler #(
  parameter int N_PINS = 4,
  parameter int N_EDGE = 2,
  parameter int STAGES = 2,
  parameter int DIV    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins,
  output logic              tick,
  output logic [N_PINS-1:0] level,
  output logic [N_EDGE-1:0] fall
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0]     mc_q;
  logic [N_EDGE-1:0] prev_q;

  assign tick = (mc_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mc_q <= '0;
    else        mc_q <= tick ? '0 : mc_q + 1'b1;
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], pins[g]};
    end
    assign level[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= '0;
    else if (tick) prev_q <= level[N_EDGE-1:0];
  end

  assign fall = {N_EDGE{tick}} & prev_q & ~level[N_EDGE-1:0];

endmodule

// File: rtl/tmr_pair_unit.sv
module tmr_pair_unit
  import tmr_pair_pkg::*;
#(
  parameter bit CAN_SPLIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              inc_a,
  input  logic              inc_b,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_a,
  output logic              ovf_b
);
  logic              split_on;
  logic [BYTE_W-1:0] lo_d, hi_d;
  logic [BYTE_W:0]   inc_lo, inc_hi;
  step_t             st;

  if (CAN_SPLIT) begin : g_split
    assign split_on = (mode == MD_SPLIT);
  end else begin : g_whole
    assign split_on = 1'b0;
  end

  assign inc_lo = byte_inc(lo);
  assign inc_hi = byte_inc(hi);
  assign st     = cnt_step(mode, lo, hi);

  always_comb begin
    lo_d  = lo;
    hi_d  = hi;
    ovf_a = 1'b0;
    ovf_b = 1'b0;
    if (split_on) begin
      if (wr_lo) lo_d = wdata;
      else if (inc_a) begin
        lo_d  = inc_lo[BYTE_W-1:0];
        ovf_a = inc_lo[BYTE_W];
      end
      if (wr_hi) hi_d = wdata;
      else if (inc_b) begin
        hi_d  = inc_hi[BYTE_W-1:0];
        ovf_b = inc_hi[BYTE_W];
      end
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
    end else if (inc_a && mode != MD_SPLIT) begin
      lo_d  = st.lo;
      hi_d  = st.hi;
      ovf_a = st.ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_d;
      hi <= hi_d;
    end
  end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int MC_DIV      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              ev0_pin,
  input  logic              ev1_pin,
  input  logic              gate0_pin,
  input  logic              gate1_pin,
  output logic              t1_ovf
);
  localparam int N_TMR = 2;

  logic [BYTE_W-1:0] mode_q;
  logic [N_TMR-1:0]  run_q;
  logic [N_TMR-1:0]  flag_q;
  logic              t1_ovf_q;

  logic              mc_tick;
  logic [3:0]        lvl;
  logic [N_TMR-1:0]  fall;

  tmode_e            md0, md1;
  logic              cs0, cs1, gm0, gm1;
  logic              en0, en1, inc0, inc0b, inc1;
  logic              split;
  logic              wr_t0l, wr_t0h, wr_t1l, wr_t1h, wr_t0_any;
  logic [BYTE_W-1:0] t0_lo, t0_hi, t1_lo, t1_hi;
  logic              ev_t0a, ev_t0b, ev_t1, ev_t1b;
  logic [N_TMR-1:0]  set_vec, clr_vec;

  tmr_pair_sampler #(
    .N_PINS(4), .N_EDGE(N_TMR), .STAGES(SYNC_STAGES), .DIV(MC_DIV)
  ) u_samp (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  ({gate1_pin, gate0_pin, ev1_pin, ev0_pin}),
    .tick  (mc_tick),
    .level (lvl),
    .fall  (fall)
  );

  assign md0 = tmode_e'(mode_q[1:0]);
  assign cs0 = mode_q[2];
  assign gm0 = mode_q[3];
  assign md1 = tmode_e'(mode_q[5:4]);
  assign cs1 = mode_q[6];
  assign gm1 = mode_q[7];

  assign split = (md0 == MD_SPLIT);

  assign en0   = run_q[0] & (~gm0 | lvl[2]);
  assign en1   = run_q[1] & (~gm1 | lvl[3]);
  assign inc0  = en0 & (cs0 ? fall[0] : mc_tick);
  assign inc1  = en1 & (cs1 ? fall[1] : mc_tick);
  assign inc0b = run_q[1] & mc_tick;

  assign wr_t0l    = wr_en && (wr_addr == A_T0L);
  assign wr_t0h    = wr_en && (wr_addr == A_T0H);
  assign wr_t1l    = wr_en && (wr_addr == A_T1L);
  assign wr_t1h    = wr_en && (wr_addr == A_T1H);
  assign wr_t0_any = wr_t0l | wr_t0h;

  tmr_pair_unit #(.CAN_SPLIT(1'b1)) u_t0 (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (md0),
    .inc_a (inc0),
    .inc_b (inc0b),
    .wr_lo (wr_t0l),
    .wr_hi (wr_t0h),
    .wdata (wr_data),
    .lo    (t0_lo),
    .hi    (t0_hi),
    .ovf_a (ev_t0a),
    .ovf_b (ev_t0b)
  );

  tmr_pair_unit #(.CAN_SPLIT(1'b0)) u_t1 (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (md1),
    .inc_a (inc1),
    .inc_b (1'b0),
    .wr_lo (wr_t1l),
    .wr_hi (wr_t1h),
    .wdata (wr_data),
    .lo    (t1_lo),
    .hi    (t1_hi),
    .ovf_a (ev_t1),
    .ovf_b (ev_t1b)
  );

  assign set_vec = {split ? ev_t0b : (ev_t1 | ev_t1b), ev_t0a};
  assign clr_vec = (wr_en && wr_addr == A_FLAG) ? wr_data[N_TMR-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      run_q    <= '0;
      flag_q   <= '0;
      t1_ovf_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data;
      if (wr_en && wr_addr == A_RUN)  run_q  <= wr_data[N_TMR-1:0];
      flag_q   <= set_vec | (flag_q & ~clr_vec);
      t1_ovf_q <= ev_t1;
    end
  end

  assign t1_ovf = t1_ovf_q;

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = mode_q;
      A_RUN:   rd_data = {{(BYTE_W-N_TMR){1'b0}}, run_q};
      A_FLAG:  rd_data = {{(BYTE_W-N_TMR){1'b0}}, flag_q};
      A_T0L:   rd_data = t0_lo;
      A_T0H:   rd_data = t0_hi;
      A_T1L:   rd_data = t1_lo;
      A_T1H:   rd_data = t1_hi;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int DIV = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       en0,
  input logic       wr_t0,
  input logic [7:0] t0_lo,
  input logic       split,
  input logic       ev_t0a,
  input logic       ev_t0b,
  input logic       ev_t1,
  input logic [1:0] flag,
  input logic [1:0] clr,
  input logic       t1_ovf
);
  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 8'd1;
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == 8'(DIV - 1)));

  p_tick_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == 8'(DIV - 1)) |-> tick);

  p_hold_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !wr_t0) |=> $stable(t0_lo));

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_t0a |=> flag[0]);

  p_flag_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !clr[0]) |=> flag[0]);

  p_split_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !ev_t0b && !flag[1]) |=> !flag[1]);

  p_split_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (split && ev_t0b) |=> flag[1]);

  p_pulse_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_t1 |=> t1_ovf);

  p_pulse_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_t1 |=> !t1_ovf);

endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (mc_tick),
  .en0    (en0),
  .wr_t0  (wr_t0_any),
  .t0_lo  (t0_lo),
  .split  (split),
  .ev_t0a (ev_t0a),
  .ev_t0b (ev_t0b),
  .ev_t1  (ev_t1),
  .flag   (flag_q),
  .clr    (clr_vec),
  .t1_ovf (t1_ovf)
);

// File: tb/tmr_pair_bench.sv
`timescale 1ns/1ps
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] pins = '0;
  logic       t1_ovf;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data),
    .ev0_pin (pins[0]), .ev1_pin (pins[1]),
    .gate0_pin (pins[2]), .gate1_pin (pins[3]),
    .t1_ovf (t1_ovf)
  );

  // behavioural reference model
  int m_mode = 0, m_run = 0, m_f0 = 0, m_f1 = 0;
  int t0l = 0, t0h = 0, t1l = 0, t1h = 0;
  int phase = 0, m_pulse = 0;
  bit [3:0] sy1 = '0, sy2 = '0;
  bit [1:0] prv = '0;

  task automatic step_cnt(input int md, inout int lo, inout int hi, output bit ev);
    int v;
    ev = 0;
    if (md == 0) begin
      v = hi * 32 + (lo % 32) + 1;
      if (v == 8192) begin v = 0; ev = 1; end
      hi = v / 32;
      lo = (lo / 32) * 32 + (v % 32);
    end else if (md == 1) begin
      v = hi * 256 + lo + 1;
      if (v == 65536) begin v = 0; ev = 1; end
      hi = v / 256;
      lo = v % 256;
    end else if (md == 2) begin
      if (lo == 255) begin lo = hi; ev = 1; end
      else lo = lo + 1;
    end
  endtask

  always @(posedge clk) begin
    bit tk, f0, f1, en0, en1, in0, in1, spl, e0, eb, e1;
    bit w0l, w0h, w1l, w1h;
    int md0, md1, clr;
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_f0 = 0; m_f1 = 0;
      t0l = 0; t0h = 0; t1l = 0; t1h = 0;
      phase = 0; m_pulse = 0; sy1 = '0; sy2 = '0; prv = '0;
    end else begin
      tk  = (phase == 11);
      f0  = tk && prv[0] && !sy2[0];
      f1  = tk && prv[1] && !sy2[1];
      md0 = m_mode % 4;
      md1 = (m_mode / 16) % 4;
      en0 = (m_run % 2 == 1) && (((m_mode / 8) % 2 == 0) || sy2[2]);
      en1 = ((m_run / 2) % 2 == 1) && (((m_mode / 128) % 2 == 0) || sy2[3]);
      in0 = en0 && ((((m_mode / 4) % 2) == 1) ? f0 : tk);
      in1 = en1 && ((((m_mode / 64) % 2) == 1) ? f1 : tk);
      spl = (md0 == 3);
      w0l = wr_en && wr_addr == 3; w0h = wr_en && wr_addr == 4;
      w1l = wr_en && wr_addr == 5; w1h = wr_en && wr_addr == 6;
      e0 = 0; eb = 0; e1 = 0;
      if (spl) begin
        if (w0l) t0l = wr_data;
        else if (in0) begin
          if (t0l == 255) begin t0l = 0; e0 = 1; end else t0l++;
        end
        if (w0h) t0h = wr_data;
        else if (((m_run / 2) % 2 == 1) && tk) begin
          if (t0h == 255) begin t0h = 0; eb = 1; end else t0h++;
        end
      end else if (w0l || w0h) begin
        if (w0l) t0l = wr_data;
        if (w0h) t0h = wr_data;
      end else if (in0) step_cnt(md0, t0l, t0h, e0);
      if (w1l || w1h) begin
        if (w1l) t1l = wr_data;
        if (w1h) t1h = wr_data;
      end else if (in1 && md1 != 3) step_cnt(md1, t1l, t1h, e1);
      clr = (wr_en && wr_addr == 2) ? wr_data % 4 : 0;
      if (clr % 2 == 1) m_f0 = 0;
      if (clr / 2 == 1) m_f1 = 0;
      if (e0) m_f0 = 1;
      if (spl ? eb : e1) m_f1 = 1;
      m_pulse = e1;
      if (wr_en && wr_addr == 0) m_mode = wr_data;
      if (wr_en && wr_addr == 1) m_run = wr_data % 4;
      if (tk) prv = sy2[1:0];
      phase = tk ? 0 : phase + 1;
      sy2 = sy1;
      sy1 = pins;
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return m_mode;
      1: return m_run;
      2: return m_f1 * 2 + m_f0;
      3: return t0l;
      4: return t0h;
      5: return t1l;
      6: return t1h;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare against the model every clock, rotating the read address
  int sel = 0;
  always @(negedge clk) begin
    if (!done) begin
      rd_addr = 3'(sel);
      #1;
      check(cur_req, $sformatf("rd[%0d]", sel), int'(rd_data), model_read(sel));
      check(cur_req, "t1_ovf", int'(t1_ovf), m_pulse);
      sel = (sel == 7) ? 0 : sel + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired, actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wiggle(input int mask, input int half, input int n);
    for (int i = 0; i < n; i++) begin
      pins = pins | 4'(mask);
      idle(half);
      pins = pins & ~4'(mask);
      idle(half);
    end
  endtask

  initial begin
    cur_req = "R1";
    idle(6);
    rst_n = 1'b1;
    idle(16);

    cur_req = "R13";
    wr(0, 8'hA5); idle(8);
    wr(0, 8'h00); idle(8);

    cur_req = "R2";
    wr(0, 8'h11); wr(1, 3); idle(400);

    cur_req = "R6";
    wr(1, 0); wr(3, 8'hF0); wr(4, 8'hFF); wr(1, 1); idle(250);
    cur_req = "R10";
    wr(2, 3); idle(20);

    cur_req = "R5";
    wr(1, 0); wr(0, 8'h10); wr(3, 8'hFC); wr(4, 8'hFF); wr(2, 3);
    wr(1, 1); idle(120);

    cur_req = "R7";
    wr(1, 0); wr(0, 8'h12); wr(4, 8'hF0); wr(3, 8'hFD); wr(2, 3);
    wr(1, 1); idle(260);

    cur_req = "R3";
    wr(1, 0); wr(0, 8'h55); wr(3, 0); wr(4, 0); wr(5, 0); wr(6, 0);
    wr(1, 3);
    wiggle(3, 20, 20);
    wiggle(3, 3, 40);
    wiggle(1, 9, 20);

    cur_req = "R4";
    wr(1, 0); wr(0, 8'h59); wr(3, 0); wr(4, 0); wr(1, 3);
    wiggle(4, 50, 6);
    wr(1, 0); idle(60);

    cur_req = "R8";
    wr(0, 8'h13); wr(3, 8'hF8); wr(4, 8'hFA); wr(5, 8'hF0); wr(6, 8'hFF);
    wr(2, 3); wr(1, 3); idle(150);
    cur_req = "R9";
    idle(150);
    wr(2, 3); wr(5, 8'hFE); wr(6, 8'hFF); idle(60);

    cur_req = "R12";
    wr(1, 0); wr(0, 8'h31); wr(5, 8'hFF); wr(6, 8'hFF); wr(1, 3); idle(100);
    wr(5, 8'h12); idle(40);

    cur_req = "R11";
    wr(1, 0); wr(0, 8'h11); wr(1, 3);
    for (int i = 0; i < 60; i++) begin
      wr(3, 8'hF0 + i); idle(i % 5);
    end
    for (int i = 0; i < 30; i++) begin
      wr(5, 8'hFF); wr(6, 8'hFF); idle(i % 3);
    end

    cur_req = "R10";
    wr(1, 0); wr(4, 8'hFF); wr(3, 8'hFF); wr(0, 8'h12); wr(1, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h01;
    idle(120);
    wr_en = 1'b0;
    idle(30);

    done = 1'b1;
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule